// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

This block sits between a set of peripheral request flags and a processor core. It merges eighteen request sources into ten vectors and chooses which vector to offer the core. It also tracks how deeply interrupt handlers are nested. Each vector takes one of three priority levels: low, high or highest. The first two vectors can be raised to highest. The other eight can be raised only to high. A request is offered only when its level is strictly above the level of the handler now running. This gives three-deep nesting with no preemption at equal level.

When a request wins, the block raises `irqReq` and presents the vector address. Both stay frozen until the core acknowledges. The acknowledge records the accepted level on a small in-service stack. A return strobe removes the most recent level, and requests that were blocked by it become eligible again.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irqReq` is 0 and no level is in service.
- R2: The sources map to vectors in index order, in groups of 1,1,3,2,1,2,1,2,3,2 sources for vectors 0 to 9. So sources 2-4 feed vector 2 and source 14 feeds vector 8. A vector requests when any of its sources has both its flag bit and its enable bit set. A source whose enable bit is 0 has no effect.
- R3: Vector k is presented at address 0x0003 + 8·k, which gives 0x0003 for vector 0 and 0x004B for vector 9.
- R4: `vecLevelSel[k]` = 0 gives vector k the low level. A value of 1 gives the highest level to vectors 0 and 1, and the high level to vectors 2 to 9.
- R5: Among the candidate requests, the one with the greatest level is selected, ordered highest > high > low.
- R6: Among candidates of equal level, the one with the smallest vector index is selected.
- R7: With nothing in service, a low-level request is accepted. `irqReq` rises on the clock edge after the request is presented.
- R8: A request whose level is equal to or below the level in service is not offered.
- R9: An acknowledge pushes the accepted level onto a three-entry in-service stack. A return pops the top entry, so a request blocked only by that entry becomes eligible again.
- R10: Once raised, `irqReq` and `vecAddr` hold their values until acknowledged, even if a higher request arrives in the meantime. `irqReq` falls on the edge that samples the acknowledge.
- R11: An acknowledge while `irqReq` is 0 has no effect. A return with an empty stack has no effect. A return in the same cycle as an accepted acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcFlag | input | 18 | Request flag of each source |
| srcEnable | input | 18 | Enable bit of each source |
| vecLevelSel | input | 10 | Level select per vector (0 low, 1 raised) |
| intAck | input | 1 | Core accepts the offered vector |
| intRet | input | 1 | Core leaves the current handler |
| irqReq | output | 1 | Interrupt request to the core |
| vecAddr | output | 16 | Address of the offered vector |

## Verification
The stimulus climbs through all three levels one at a time, then unwinds with returns. This separates a correct compare against the top of the stack from one that uses the wrong entry or lets a level through when it only equals the level in service. Simultaneous mixed-level and equal-level requests test the level ordering apart from the index ordering. A higher request arriving while one is offered shows whether the offer is frozen. Idle acknowledges, surplus returns and a return paired with an acknowledge each leave a visible trace on later acceptance whenever the stack has been corrupted.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } lvl_e;

  localparam int VEC_COUNT   = 10;
  localparam int SRC_COUNT   = 18;
  localparam int STACK_DEPTH = 3;
  localparam int SRC_PER_VEC [VEC_COUNT] = '{1, 1, 3, 2, 1, 2, 1, 2, 3, 2};

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic push;
    logic pop;
  } strb_t;

  function automatic logic [SRC_COUNT-1:0] srcMask(input int vec);
    int first;
    logic [SRC_COUNT-1:0] m;
    first = 0;
    for (int k = 0; k < VEC_COUNT; k++)
      if (k < vec) first += SRC_PER_VEC[k];
    m = '0;
    for (int s = 0; s < SRC_COUNT; s++)
      if (s >= first && s < first + SRC_PER_VEC[vec]) m[s] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ivc_datapath.sv
module ivc_datapath
  import ivc_pkg::*;
#(
  parameter int NUM_TOP_VEC = 2,
  parameter int ADDR_W      = 16,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] srcFlag,
  input  logic [SRC_COUNT-1:0] srcEnable,
  input  logic [VEC_COUNT-1:0] vecLevelSel,
  input  strb_t                strb,
  output logic                 candAccept,
  output logic                 stackEmpty,
  output logic [ADDR_W-1:0]    vecAddr
);
  localparam int IDX_W   = $clog2(VEC_COUNT);
  localparam int DEPTH_W = $clog2(STACK_DEPTH + 1);
  localparam logic [DEPTH_W-1:0] ONE = 1;

  logic [VEC_COUNT-1:0] vecReq;
  lvl_e                 vecLvl [VEC_COUNT];
  lvl_e                 bestLvl, curLvl, selLvl;
  logic [IDX_W-1:0]     bestIdx, selIdx;
  lvl_e                 stk [STACK_DEPTH];
  logic [DEPTH_W-1:0]   depth;

  for (genvar v = 0; v < VEC_COUNT; v++) begin : g_vec
    assign vecReq[v] = |(srcFlag & srcEnable & srcMask(v));
    if (v < NUM_TOP_VEC) begin : g_top
      assign vecLvl[v] = vecLevelSel[v] ? LVL_TOP : LVL_LOW;
    end else begin : g_high
      assign vecLvl[v] = vecLevelSel[v] ? LVL_HIGH : LVL_LOW;
    end
  end

  // strict compare keeps the lowest index among equal levels
  always_comb begin
    bestLvl = LVL_NONE;
    bestIdx = '0;
    for (int i = 0; i < VEC_COUNT; i++) begin
      if (vecReq[i] && (vecLvl[i] > bestLvl)) begin
        bestLvl = vecLvl[i];
        bestIdx = IDX_W'(i);
      end
    end
  end

  assign stackEmpty = (depth == '0);
  assign curLvl     = stackEmpty ? LVL_NONE : stk[depth - ONE];
  assign candAccept = (bestLvl > curLvl);
  assign vecAddr    = ADDR_W'(VEC_BASE + VEC_STRIDE * int'(selIdx));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selIdx <= '0;
      selLvl <= LVL_NONE;
    end else if (strb.capture) begin
      selIdx <= bestIdx;
      selLvl <= bestLvl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth <= '0;
      for (int e = 0; e < STACK_DEPTH; e++) stk[e] <= LVL_NONE;
    end else if (strb.push) begin
      stk[depth] <= selLvl;
      depth      <= depth + ONE;
    end else if (strb.pop) begin
      depth <= depth - ONE;
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (depth < DEPTH_W'(STACK_DEPTH)))
    else $error("push onto full in-service stack");

  // R8
  nest_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (selLvl > curLvl))
    else $error("accepted level not above level in service");

  // R11
  pop_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !stackEmpty)
    else $error("pop from empty in-service stack");
endmodule

// File: rtl/ivc_control.sv
module ivc_control
  import ivc_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  candAccept,
  input  logic  stackEmpty,
  input  logic  ackIn,
  input  logic  retIn,
  output strb_t strb,
  output logic  irqReq
);
  logic pendQ;
  logic ackTaken;

  assign ackTaken     = ackIn && pendQ;
  assign strb.capture = !pendQ && candAccept;
  assign strb.push    = ackTaken;
  assign strb.pop     = retIn && !ackTaken && !stackEmpty;
  assign irqReq       = pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pendQ <= 1'b0;
    else if (strb.capture) pendQ <= 1'b1;
    else if (ackTaken)     pendQ <= 1'b0;
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !ackIn) |=> pendQ)
    else $error("request withdrawn before acknowledge");

  // R10
  drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && ackIn) |=> !pendQ)
    else $error("request kept after acknowledge");
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_TOP_VEC = 2,
  parameter int ADDR_W      = 16,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] srcFlag,
  input  logic [SRC_COUNT-1:0] srcEnable,
  input  logic [VEC_COUNT-1:0] vecLevelSel,
  input  logic                 intAck,
  input  logic                 intRet,
  output logic                 irqReq,
  output logic [ADDR_W-1:0]    vecAddr
);
  strb_t strb;
  logic  candAccept;
  logic  stackEmpty;

  ivc_control u_ctrl (
    .clk(clk), .rstN(rstN), .candAccept(candAccept), .stackEmpty(stackEmpty),
    .ackIn(intAck), .retIn(intRet), .strb(strb), .irqReq(irqReq)
  );

  ivc_datapath #(
    .NUM_TOP_VEC(NUM_TOP_VEC), .ADDR_W(ADDR_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcFlag(srcFlag), .srcEnable(srcEnable),
    .vecLevelSel(vecLevelSel), .strb(strb), .candAccept(candAccept),
    .stackEmpty(stackEmpty), .vecAddr(vecAddr)
  );

  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !intAck) |=> $stable(vecAddr))
    else $error("vector address moved while offered");
endmodule

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] srcFlag = '0;
  logic [17:0] srcEnable = '1;
  logic [9:0]  vecLevelSel = '0;
  logic        intAck = 1'b0;
  logic        intRet = 1'b0;
  logic        irqReq;
  logic [15:0] vecAddr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string curTag = "R8 no request expected";
  logic [15:0] expAddr[$];
  string       expTag[$];

  always #2 clk = ~clk;

  irq_nest_ctrl uut (
    .clk(clk), .rstN(rstN), .srcFlag(srcFlag), .srcEnable(srcEnable),
    .vecLevelSel(vecLevelSel), .intAck(intAck), .intRet(intRet),
    .irqReq(irqReq), .vecAddr(vecAddr)
  );

  // monitor: compares each new request against the scoreboard
  initial begin
    logic prevReq;
    prevReq = 1'b0;
    forever begin
      @(negedge clk);
      if (irqReq && !prevReq) begin
        checks++;
        if (expAddr.size() == 0) begin
          fails++;
          $display("FAIL %s: unexpected request, actual vecAddr=%h expected none", curTag, vecAddr);
        end else begin
          logic [15:0] a;
          string t;
          a = expAddr.pop_front();
          t = expTag.pop_front();
          if (vecAddr !== a) begin
            fails++;
            $display("FAIL %s: actual vecAddr=%h expected %h", t, vecAddr, a);
          end
        end
      end
      prevReq = irqReq;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expectReq(input logic [15:0] a, input string tag);
    expAddr.push_back(a);
    expTag.push_back(tag);
    for (int i = 0; i < 10 && expAddr.size() != 0; i++) @(negedge clk);
    if (expAddr.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL %s: actual no request expected vecAddr=%h", tag, a);
      expAddr.delete();
      expTag.delete();
    end
  endtask

  task automatic ackClear(input int src);
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
    srcFlag[src] = 1'b0;
    check(irqReq == 1'b0, "R10 request drops after acknowledge", 16'(irqReq), 16'h0);
  endtask

  task automatic retPulse();
    @(negedge clk);
    intRet = 1'b1;
    @(negedge clk);
    intRet = 1'b0;
  endtask

  task automatic noAccept(input string tag);
    curTag = tag;
    repeat (3) @(negedge clk);
    check(irqReq == 1'b0, tag, 16'(irqReq), 16'h0);
    curTag = "R8 no request expected";
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(irqReq == 1'b0, "R1 no request after reset", 16'(irqReq), 16'h0);

    // climb through the three levels
    srcFlag[0] = 1'b1;
    expectReq(16'h0003, "R7 R3 low request on empty stack");
    repeat (3) @(negedge clk);
    check(irqReq && vecAddr == 16'h0003, "R10 offer held without acknowledge", vecAddr, 16'h0003);
    ackClear(0);
    srcFlag[7] = 1'b1;
    noAccept("R8 low blocked by low in service");
    vecLevelSel[4] = 1'b1;
    expectReq(16'h0023, "R4 vector4 raised to high");
    ackClear(7);
    srcFlag[12] = 1'b1;
    vecLevelSel[7] = 1'b1;
    noAccept("R8 high blocked by high in service");
    srcFlag[1] = 1'b1;
    vecLevelSel[1] = 1'b1;
    expectReq(16'h000B, "R4 vector1 raised to highest");
    ackClear(1);

    // unwind
    retPulse();
    noAccept("R9 one return leaves high in service");
    retPulse();
    expectReq(16'h003B, "R9 high accepted after second return");
    ackClear(12);
    retPulse();
    retPulse();
    retPulse();
    vecLevelSel = '0;
    srcFlag[10] = 1'b1;
    expectReq(16'h0033, "R11 surplus return left stack empty");
    ackClear(10);
    retPulse();

    // simultaneous requests
    vecLevelSel[9] = 1'b1;
    srcFlag[16] = 1'b1;
    srcFlag[14] = 1'b1;
    srcFlag[5] = 1'b1;
    expectReq(16'h004B, "R5 high beats simultaneous lows");
    ackClear(16);
    vecLevelSel = '0;
    noAccept("R8 lows blocked by high in service");
    retPulse();
    expectReq(16'h001B, "R6 vector3 before vector8 at equal level");
    srcFlag[0] = 1'b1;
    vecLevelSel[0] = 1'b1;
    repeat (3) @(negedge clk);
    check(irqReq && vecAddr == 16'h001B, "R10 offer frozen despite higher arrival", vecAddr, 16'h001B);
    ackClear(5);
    expectReq(16'h0003, "R5 highest accepted over low in service");
    ackClear(0);
    vecLevelSel = '0;
    retPulse();
    retPulse();
    expectReq(16'h0043, "R2 source14 feeds vector8");
    ackClear(14);
    retPulse();

    // enable masking
    srcEnable[2] = 1'b0;
    srcFlag[2] = 1'b1;
    noAccept("R2 disabled source ignored");
    srcEnable[2] = 1'b1;
    expectReq(16'h0013, "R2 source2 feeds vector2");
    ackClear(2);
    retPulse();

    // idle acknowledge and acknowledge paired with return
    @(negedge clk);
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
    srcFlag[17] = 1'b1;
    expectReq(16'h004B, "R11 idle acknowledge ignored");
    intAck = 1'b1;
    intRet = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
    intRet = 1'b0;
    srcFlag[17] = 1'b0;
    check(irqReq == 1'b0, "R10 request drops after acknowledge", 16'(irqReq), 16'h0);
    srcFlag[10] = 1'b1;
    noAccept("R11 return ignored alongside acknowledge");
    retPulse();
    expectReq(16'h0033, "R11 low accepted after later return");
    ackClear(10);
    retPulse();

    check(expAddr.size() == 0, "R9 scoreboard drained", 16'(expAddr.size()), 16'h0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual run unfinished expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule